// File: doc/BRIEF.md
# Card slot power mode controller

This block is the digital decision core of a power switch for one hot-plug card slot. It watches three rail-good flags (auxiliary, 3.3 V primary, 1.5 V primary), an active-low shutdown request, an active-low standby request and two active-low card-detect lines. From these it decides which of the three slot switches conduct and which output discharge devices pull the slot rails to ground. It also reports the resulting mode as a 3-bit code.

The decision depends on history. A card that was powered when a primary rail disappears keeps its auxiliary supply. A card that arrives while a primary rail is already missing, or while standby is requested, gets no power at all until both primary rails are good and standby is released. Shutdown overrides everything except a missing auxiliary rail. Releasing shutdown brings back the mode that was in force before it.

Each switch and its discharge device are sequenced so that they are never on together. Each one must stay off for a programmable number of cycles before the other turns on. All inputs are asynchronous and pass through two flip-flops before use.

Top module: `slot_pwr_ctl`

## Requirements
- R1: `mode` uses the codes OFF=0, Shutdown=1, No Card=2, Standby=3, Card Inserted=4. Vector bit 0 of `sw_en`/`dis_en` is the auxiliary rail, bit 1 the 3.3 V rail and bit 2 the 1.5 V rail.
- R2: While `aux_ok` is low, `mode` is OFF, and all switch and discharge enables settle to 0, whatever the other inputs are.
- R3: With `aux_ok` high and `shdn_n` low, `mode` is Shutdown, all switches are off and all three discharge enables are on.
- R4: When `shdn_n` returns high with the other inputs unchanged, the mode held just before shutdown is restored, together with its outputs.
- R5: With `aux_ok` high, no shutdown and both card lines high, `mode` is No Card, all switches are off and all discharge enables are on.
- R6: A card counts as present when either card line is low. If all three rails are good and `stby_n` is high when the card is detected, `mode` becomes Card Inserted, all three switches turn on and all discharge enables turn off.
- R7: From Card Inserted, a low `stby_n` or the loss of either primary rail gives Standby: only the auxiliary switch stays on. When the cause goes away, the block returns to Card Inserted.
- R8: A card detected while a primary rail is missing, or while `stby_n` is low, gives `mode` OFF with no switch and no discharge enabled. Once both primary rails are good and `stby_n` is high, the block enters Card Inserted.
- R9: On each rail, the switch and discharge enables are never high together. A discharge enable rises only after its switch has been off for at least GAP cycles, and a switch rises only after its discharge enable has been off for at least GAP cycles.
- R10: Inputs are synchronised through two flip-flops. A change of inputs first shows on `mode` after the third rising clock edge following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_ok | input | 1 | Auxiliary rail present |
| p33_ok | input | 1 | 3.3 V primary rail present |
| p15_ok | input | 1 | 1.5 V primary rail present |
| shdn_n | input | 1 | Shutdown request, active low |
| stby_n | input | 1 | Standby request, active low |
| cpa_n | input | 1 | Card-detect line A, active low |
| cpb_n | input | 1 | Card-detect line B, active low |
| sw_en | output | 3 | Switch enables (bit 0 aux, 1 3.3 V, 2 1.5 V) |
| dis_en | output | 3 | Discharge enables (same bit order) |
| mode | output | 3 | Mode code (see R1) |

## Verification
The embedded properties look only at the synchronised copies of the inputs and at registered outputs. They therefore assume nothing about when the raw pins toggle, except that a level seen by the second flip-flop stands for the actual input. The two-cycle look-back in the sequencing properties relies on every rail being dark during reset. The bench changes inputs only on falling clock edges. It holds each setting well past the synchroniser, mode register and gap counter before sampling the steady state, so that every check sees a settled mode.

// File: rtl/slot_pwr_ctl.sv
module slot_pwr_ctl #(
  parameter int GAP = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_ok,
  input  logic       p33_ok,
  input  logic       p15_ok,
  input  logic       shdn_n,
  input  logic       stby_n,
  input  logic       cpa_n,
  input  logic       cpb_n,
  output logic [2:0] sw_en,
  output logic [2:0] dis_en,
  output logic [2:0] mode
);
  localparam int CW = (GAP < 1) ? 1 : $clog2(GAP + 1);
  localparam logic [CW-1:0] GAP_C = CW'(GAP);
  localparam logic [6:0] SYNC_RST = 7'b0001111;

  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_SHDN = 3'd1;
  localparam logic [2:0] M_NONE = 3'd2;
  localparam logic [2:0] M_STBY = 3'd3;
  localparam logic [2:0] M_ON   = 3'd4;

  typedef enum logic [1:0] {B_NOCARD, B_IDLE, B_STBY, B_ON} base_t;

  logic [6:0] s1, s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= SYNC_RST;
      s2 <= SYNC_RST;
    end else begin
      s1 <= {aux_ok, p33_ok, p15_ok, shdn_n, stby_n, cpa_n, cpb_n};
      s2 <= s1;
    end

  logic aux_s, shdn_s, card, prim_ok;
  assign aux_s   = s2[6];
  assign shdn_s  = s2[3];
  assign card    = !s2[1] || !s2[0];
  assign prim_ok = s2[5] && s2[4] && s2[2];

  base_t base_q, base_n;
  always_comb begin
    base_n = base_q;
    if (!aux_s) base_n = B_NOCARD;
    else if (shdn_s) begin
      if (!card) base_n = B_NOCARD;
      else case (base_q)
        B_NOCARD: base_n = prim_ok ? B_ON : B_IDLE;
        B_IDLE:   if (prim_ok) base_n = B_ON;
        B_ON:     if (!prim_ok) base_n = B_STBY;
        B_STBY:   if (prim_ok) base_n = B_ON;
        default:  base_n = B_NOCARD;
      endcase
    end
  end

  logic [2:0] mode_n, mode_q;
  always_comb begin
    if (!aux_s)       mode_n = M_OFF;
    else if (!shdn_s) mode_n = M_SHDN;
    else case (base_n)
      B_NOCARD: mode_n = M_NONE;
      B_STBY:   mode_n = M_STBY;
      B_ON:     mode_n = M_ON;
      default:  mode_n = M_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      base_q <= B_NOCARD;
      mode_q <= M_OFF;
    end else begin
      base_q <= base_n;
      mode_q <= mode_n;
    end

  logic [2:0] want_sw, want_dis;
  assign want_sw[0] = (mode_q == M_ON) || (mode_q == M_STBY);
  assign want_sw[1] = (mode_q == M_ON);
  assign want_sw[2] = (mode_q == M_ON);
  assign want_dis   = {3{(mode_q == M_SHDN) || (mode_q == M_NONE)}};

  logic [2:0] sw_q, dis_q;

  for (genvar i = 0; i < 3; i++) begin : g_rail
    logic [CW-1:0] idle_q;
    logic          ready;
    assign ready = (idle_q == GAP_C);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sw_q[i]  <= 1'b0;
        dis_q[i] <= 1'b0;
        idle_q   <= '0;
      end else begin
        sw_q[i]  <= want_sw[i]  && (sw_q[i]  || (!dis_q[i] && ready));
        dis_q[i] <= want_dis[i] && (dis_q[i] || (!sw_q[i]  && ready));
        if (sw_q[i] || dis_q[i]) idle_q <= '0;
        else if (!ready)         idle_q <= idle_q + 1'b1;
      end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_q[i] && dis_q[i])); // R9
    AST_DIS_AFTER_SW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis_q[i]) |-> (!$past(sw_q[i]) && !$past(sw_q[i], 2))); // R9
    AST_SW_AFTER_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_q[i]) |-> (!$past(dis_q[i]) && !$past(dis_q[i], 2))); // R9
  end

  AST_AUX_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_s |=> (mode_q == M_OFF)); // R2
  AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |=> (sw_q == 3'b000 && dis_q == 3'b000)); // R2
  AST_SHDN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_s && !shdn_s) |=> (mode_q == M_SHDN)); // R3
  AST_PRIMARY_NEEDS_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q[1] || sw_q[2]) |-> sw_q[0]); // R7
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= M_ON); // R1

  assign sw_en  = sw_q;
  assign dis_en = dis_q;
  assign mode   = mode_q;
endmodule

// File: tb/slot_pwr_ctl_tb.sv
module slot_pwr_ctl_tb;
  localparam int GAP = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aux_ok = 0, p33_ok = 0, p15_ok = 0;
  logic shdn_n = 1, stby_n = 1, cpa_n = 1, cpb_n = 1;
  logic [2:0] sw_en, dis_en, mode;

  int checks = 0;
  int fails  = 0;
  int bbm_events = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slot_pwr_ctl #(.GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .aux_ok(aux_ok), .p33_ok(p33_ok), .p15_ok(p15_ok),
    .shdn_n(shdn_n), .stby_n(stby_n), .cpa_n(cpa_n), .cpb_n(cpb_n),
    .sw_en(sw_en), .dis_en(dis_en), .mode(mode)
  );

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic expect_state(string tag, logic [2:0] m, logic [2:0] s, logic [2:0] d);
    check({tag, " mode"}, mode, m);
    check({tag, " sw_en"}, sw_en, s);
    check({tag, " dis_en"}, dis_en, d);
  endtask

  // R9 monitor: run lengths of off-time per rail, checked when the other enable rises
  int sw_off_run [3];
  int dis_off_run [3];
  logic [2:0] psw = 0, pdis = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 3; i++) begin
        if (sw_en[i] && dis_en[i]) begin
          fails++; checks++;
          $display("FAIL R9 rail %0d: sw and dis both 1, expected not both", i);
        end
        if (dis_en[i] && !pdis[i]) begin
          bbm_events++; checks++;
          if (sw_off_run[i] < GAP) begin
            fails++;
            $display("FAIL R9 rail %0d dis rose: switch off run %0d expected >= %0d", i, sw_off_run[i], GAP);
          end
        end
        if (sw_en[i] && !psw[i]) begin
          bbm_events++; checks++;
          if (dis_off_run[i] < GAP) begin
            fails++;
            $display("FAIL R9 rail %0d sw rose: discharge off run %0d expected >= %0d", i, dis_off_run[i], GAP);
          end
        end
        sw_off_run[i]  = sw_en[i]  ? 0 : sw_off_run[i] + 1;
        dis_off_run[i] = dis_en[i] ? 0 : dis_off_run[i] + 1;
      end
      psw  = sw_en;
      pdis = dis_en;
    end else begin
      for (int i = 0; i < 3; i++) begin
        sw_off_run[i] = 100;
        dis_off_run[i] = 100;
      end
    end
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    expect_state("R2 reset", 3'd0, 3'b000, 3'b000);
    rst_n = 1'b1;
    shdn_n = 1'b0;
    cpa_n = 1'b0;
    settle();
    expect_state("R2 no aux with shdn and card", 3'd0, 3'b000, 3'b000);
    shdn_n = 1'b1;
    cpa_n = 1'b1;
  endtask

  task automatic t_nocard();
    aux_ok = 1; p33_ok = 1; p15_ok = 1;
    settle();
    expect_state("R5 no card", 3'd2, 3'b000, 3'b111);
  endtask

  task automatic t_insert_latency();
    cpa_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 mode after two edges", mode, 3'd2);
    @(negedge clk);
    check("R10 mode after third edge", mode, 3'd4);
    settle();
    expect_state("R6 card on line A", 3'd4, 3'b111, 3'b000);
  endtask

  task automatic t_standby();
    stby_n = 1'b0;
    settle();
    expect_state("R7 standby request", 3'd3, 3'b001, 3'b000);
    stby_n = 1'b1;
    settle();
    expect_state("R7 standby release", 3'd4, 3'b111, 3'b000);
    p15_ok = 1'b0;
    settle();
    expect_state("R7 1.5V lost", 3'd3, 3'b001, 3'b000);
    p15_ok = 1'b1;
    settle();
    expect_state("R7 1.5V back", 3'd4, 3'b111, 3'b000);
  endtask

  task automatic t_shutdown();
    shdn_n = 1'b0;
    settle();
    expect_state("R3 shutdown from inserted", 3'd1, 3'b000, 3'b111);
    shdn_n = 1'b1;
    settle();
    expect_state("R4 restore inserted", 3'd4, 3'b111, 3'b000);
    p33_ok = 1'b0;
    settle();
    check("R7 3.3V lost", mode, 3'd3);
    shdn_n = 1'b0;
    settle();
    expect_state("R3 shutdown from standby", 3'd1, 3'b000, 3'b111);
    shdn_n = 1'b1;
    settle();
    expect_state("R4 restore standby", 3'd3, 3'b001, 3'b000);
    p33_ok = 1'b1;
    settle();
    check("R7 3.3V back", mode, 3'd4);
  endtask

  task automatic t_remove_lineb();
    cpa_n = 1'b1;
    settle();
    expect_state("R5 card removed", 3'd2, 3'b000, 3'b111);
    cpb_n = 1'b0;
    settle();
    expect_state("R6 card on line B", 3'd4, 3'b111, 3'b000);
    cpb_n = 1'b1;
    settle();
  endtask

  task automatic t_late_insert();
    p33_ok = 1'b0;
    cpa_n = 1'b0;
    settle();
    expect_state("R8 insert without 3.3V", 3'd0, 3'b000, 3'b000);
    stby_n = 1'b0;
    p33_ok = 1'b1;
    settle();
    expect_state("R8 rails back, standby low", 3'd0, 3'b000, 3'b000);
    stby_n = 1'b1;
    settle();
    expect_state("R8 standby released", 3'd4, 3'b111, 3'b000);
  endtask

  task automatic t_aux_loss();
    aux_ok = 1'b0;
    settle();
    expect_state("R2 aux lost with card", 3'd0, 3'b000, 3'b000);
    aux_ok = 1'b1;
    settle();
    check("R1 aux back gives inserted code", mode, 3'd4);
  endtask

  initial begin
    t_reset();
    t_nocard();
    t_insert_latency();
    t_standby();
    t_shutdown();
    t_remove_lineb();
    t_late_insert();
    t_aux_loss();
    checks++;
    if (bbm_events == 0) begin
      fails++;
      $display("FAIL R9: sequencing events %0d expected > 0", bbm_events);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule